// File: doc/BRIEF.md
# Loopback and Test-Pattern Routing Matrix

This block steers serial bits for one DS3/E3 channel. It works one bit per clock and connects four parties: the line receiver, the receive payload output, the transmit stream input and the line transmitter. It also connects to the two halves of a test-pattern unit: a generator that supplies bits and a checker that takes them in. Three loopback requests (line, diagnostic and payload) and a two-bit pattern mode decide which source feeds each destination. These choices apply only at payload bit positions. Two per-bit qualifiers mark those positions, one for the receive frame and one for the transmit frame. At overhead positions the normal traffic path is kept.

The block also provides an overhead-insert override on the line output. During diagnostic loopback it can force an all-ones alarm pattern onto the line while the real traffic still loops to the receive side. During payload loopback, the transmit data-enable strobe it returns to the upstream source follows the receive frame. Every output goes through one register stage, so each result appears one clock after the inputs that produced it.

Top module: `lbm_router`

## Requirements
- R1: While `rst_n` is low, every output is 0.
- R2: Every output equals the function below of the inputs sampled at the previous rising clock edge. In that function, d = `diag_lb`, l = `line_lb` and not d, p = `pay_lb` and neither d nor l.
- R3: With no loopback, the pattern mode sets the payload routing. When `bert_mode[1]`=0, the line payload is the generator bit, the receive output takes the line bit and the checker takes the line bit. When `bert_mode[1]`=1, the line payload is the transmit bit, the checker takes the transmit bit and the receive output takes the generator bit.
- R4: In line loopback, `line_tx_bit` equals `line_rx_bit` at every position, and overhead insert has no effect on it. The receive output still carries line data at positions where the pattern mode does not route the generator to it.
- R5: In diagnostic loopback, `line_rx_bit` and `rx_pay` are ignored. The receive side sees the composed transmit stream before any alarm substitution, and `rx_out_pay` follows `tx_pay`. With `bert_mode[1]`=1, the generator drives the receive payload and the checker takes the transmit bit.
- R6: When `diag_lb` and `ais_en` are both 1, `line_tx_bit` is 1 and the looped data is unchanged. Outside diagnostic loopback, `ais_en` has no effect.
- R7: In payload loopback, `tx_den` follows `rx_pay`. With mode 00 the line payload is the received bit. With mode 01 the line payload is the generator bit. With mode 1X the line payload is the received bit, the generator drives the receive payload and the checker takes the transmit bit.
- R8: The loopbacks have a fixed priority: diagnostic, then line, then payload.
- R9: At overhead positions the line output carries `tx_bit`, or `line_rx_bit` in line loopback. The receive output carries the receive-side stream. `chk_en` is 0 unless the checker's own source frame is at a payload position.
- R10: When `oh_en`=1, `line_tx_bit` takes `oh_bit` at any position, except in line loopback and under alarm substitution.
- R11: `gen_req` is 1 exactly when a generator bit is placed on a payload position: on the line (qualified by `tx_den`) or on the receive output (qualified by `rx_out_pay`).
- R12: `chk_en` follows the transmit-frame qualifier when the checker takes the transmit bit. Otherwise it follows the receive-frame qualifier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| diag_lb | input | 1 | Diagnostic loopback request |
| line_lb | input | 1 | Line loopback request |
| pay_lb | input | 1 | Payload loopback request |
| bert_mode | input | 2 | Pattern mode; bit 1 picks the checker direction, bit 0 picks the payload-loopback generator path |
| ais_en | input | 1 | Alarm substitution enable during diagnostic loopback |
| line_rx_bit | input | 1 | Bit from the line receiver |
| rx_pay | input | 1 | Receive-frame payload qualifier |
| tx_bit | input | 1 | Transmit stream bit (payload and formatter overhead) |
| tx_pay | input | 1 | Transmit-frame payload qualifier |
| gen_bit | input | 1 | Pattern generator bit |
| oh_en | input | 1 | Overhead insert enable |
| oh_bit | input | 1 | Overhead insert bit |
| line_tx_bit | output | 1 | Bit to the line transmitter |
| rx_out_bit | output | 1 | Receive payload output bit |
| rx_out_pay | output | 1 | Receive output payload qualifier |
| chk_bit | output | 1 | Bit to the pattern checker |
| chk_en | output | 1 | Checker bit is valid |
| gen_req | output | 1 | Generator bit consumed |
| tx_den | output | 1 | Transmit data enable returned upstream |

## Verification
All seven outputs come from one register stage, so the result of a stimulus is due exactly one clock after it. The driver sets inputs at the falling edge and queues the expected outputs for them. The monitor waits for the next rising edge plus a small delay, then takes one item from the queue and compares it, which keeps each check on the correct cycle. The pattern covers every combination of the three loopback bits, the mode and the alarm enable, each held for a run of cycles while the data and qualifiers change at random.

// File: rtl/lbm_pkg.sv
package lbm_pkg;
  localparam int BM_W = 2;

  typedef enum logic [1:0] {LB_NONE, LB_DIAG, LB_LINE, LB_PAY} lb_mode_e;
  typedef enum logic [1:0] {SRC_RX, SRC_TX, SRC_GEN, SRC_LOOP} src_e;

  typedef struct packed {
    src_e line_src;
    src_e rxo_src;
    src_e chk_src;
  } route_t;

  // Priority: diagnostic over line over payload.
  function automatic lb_mode_e resolve_mode(input logic d, input logic l, input logic p);
    if (d)      return LB_DIAG;
    else if (l) return LB_LINE;
    else if (p) return LB_PAY;
    else        return LB_NONE;
  endfunction

  // Sources for each destination at payload positions.
  function automatic route_t route_of(input lb_mode_e m, input logic [BM_W-1:0] bm);
    route_t r;
    logic toward_rx;
    toward_rx = bm[BM_W-1];
    r.rxo_src = toward_rx ? SRC_GEN : ((m == LB_DIAG) ? SRC_LOOP : SRC_RX);
    r.chk_src = toward_rx ? SRC_TX  : ((m == LB_DIAG) ? SRC_LOOP : SRC_RX);
    case (m)
      LB_NONE: r.line_src = toward_rx ? SRC_TX : SRC_GEN;
      LB_DIAG: r.line_src = SRC_TX;
      LB_LINE: r.line_src = SRC_RX;
      default: r.line_src = (!toward_rx && bm[0]) ? SRC_GEN : SRC_RX;
    endcase
    return r;
  endfunction

  function automatic logic pick(input src_e s, input logic rx, input logic tx,
                                input logic gen, input logic loop);
    case (s)
      SRC_RX:  return rx;
      SRC_TX:  return tx;
      SRC_GEN: return gen;
      default: return loop;
    endcase
  endfunction
endpackage

// File: rtl/lbm_mode_resolve.sv
module lbm_mode_resolve
  import lbm_pkg::*;
(
  input  logic            diag_lb,
  input  logic            line_lb,
  input  logic            pay_lb,
  input  logic [BM_W-1:0] bert_mode,
  input  logic            rx_pay,
  input  logic            tx_pay,
  output lb_mode_e        mode,
  output route_t          route,
  output logic            q_tx,
  output logic            q_rx
);
  always_comb begin
    mode  = resolve_mode(diag_lb, line_lb, pay_lb);
    route = route_of(mode, bert_mode);
    // Transmit frame realigns to the receive frame in payload loopback.
    q_tx  = (mode == LB_PAY) ? rx_pay : tx_pay;
    // Receive side follows the transmit frame in diagnostic loopback.
    q_rx  = (mode == LB_DIAG) ? tx_pay : rx_pay;
  end
endmodule

// File: rtl/lbm_tx_side.sv
module lbm_tx_side
  import lbm_pkg::*;
#(
  parameter logic AIS_LEVEL = 1'b1
) (
  input  lb_mode_e mode,
  input  route_t   route,
  input  logic     q_tx,
  input  logic     ais_en,
  input  logic     line_rx_bit,
  input  logic     tx_bit,
  input  logic     gen_bit,
  input  logic     oh_en,
  input  logic     oh_bit,
  output logic     line_pre,
  output logic     line_next,
  output logic     gen_on_line
);
  logic pay_bit;
  logic ais_on;

  always_comb begin
    pay_bit     = pick(route.line_src, line_rx_bit, tx_bit, gen_bit, tx_bit);
    gen_on_line = q_tx && (route.line_src == SRC_GEN);
    if (mode == LB_LINE)  line_pre = line_rx_bit;
    else if (oh_en)       line_pre = oh_bit;
    else if (q_tx)        line_pre = pay_bit;
    else                  line_pre = tx_bit;
    ais_on    = (mode == LB_DIAG) && ais_en;
    line_next = ais_on ? AIS_LEVEL : line_pre;
  end
endmodule

// File: rtl/lbm_rx_side.sv
module lbm_rx_side
  import lbm_pkg::*;
(
  input  lb_mode_e mode,
  input  route_t   route,
  input  logic     q_tx,
  input  logic     q_rx,
  input  logic     line_rx_bit,
  input  logic     line_pre,
  input  logic     tx_bit,
  input  logic     gen_bit,
  output logic     rxo_next,
  output logic     chk_next,
  output logic     chk_en_next,
  output logic     gen_on_rx
);
  logic stream;

  always_comb begin
    stream      = (mode == LB_DIAG) ? line_pre : line_rx_bit;
    rxo_next    = q_rx ? pick(route.rxo_src, line_rx_bit, tx_bit, gen_bit, line_pre)
                       : stream;
    chk_next    = pick(route.chk_src, line_rx_bit, tx_bit, gen_bit, line_pre);
    chk_en_next = (route.chk_src == SRC_TX) ? q_tx : q_rx;
    gen_on_rx   = q_rx && (route.rxo_src == SRC_GEN);
  end
endmodule

// File: rtl/lbm_router.sv
module lbm_router
  import lbm_pkg::*;
#(
  parameter logic AIS_LEVEL = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            diag_lb,
  input  logic            line_lb,
  input  logic            pay_lb,
  input  logic [BM_W-1:0] bert_mode,
  input  logic            ais_en,
  input  logic            line_rx_bit,
  input  logic            rx_pay,
  input  logic            tx_bit,
  input  logic            tx_pay,
  input  logic            gen_bit,
  input  logic            oh_en,
  input  logic            oh_bit,
  output logic            line_tx_bit,
  output logic            rx_out_bit,
  output logic            rx_out_pay,
  output logic            chk_bit,
  output logic            chk_en,
  output logic            gen_req,
  output logic            tx_den
);
  lb_mode_e mode;
  route_t   route;
  logic     q_tx, q_rx;
  logic     line_pre, line_next, gen_on_line;
  logic     rxo_next, chk_next, chk_en_next, gen_on_rx;

  lbm_mode_resolve u_mode (
    .diag_lb(diag_lb), .line_lb(line_lb), .pay_lb(pay_lb), .bert_mode(bert_mode),
    .rx_pay(rx_pay), .tx_pay(tx_pay), .mode(mode), .route(route),
    .q_tx(q_tx), .q_rx(q_rx)
  );

  lbm_tx_side #(.AIS_LEVEL(AIS_LEVEL)) u_tx (
    .mode(mode), .route(route), .q_tx(q_tx), .ais_en(ais_en),
    .line_rx_bit(line_rx_bit), .tx_bit(tx_bit), .gen_bit(gen_bit),
    .oh_en(oh_en), .oh_bit(oh_bit), .line_pre(line_pre),
    .line_next(line_next), .gen_on_line(gen_on_line)
  );

  lbm_rx_side u_rx (
    .mode(mode), .route(route), .q_tx(q_tx), .q_rx(q_rx),
    .line_rx_bit(line_rx_bit), .line_pre(line_pre), .tx_bit(tx_bit),
    .gen_bit(gen_bit), .rxo_next(rxo_next), .chk_next(chk_next),
    .chk_en_next(chk_en_next), .gen_on_rx(gen_on_rx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_tx_bit <= 1'b0;
      rx_out_bit  <= 1'b0;
      rx_out_pay  <= 1'b0;
      chk_bit     <= 1'b0;
      chk_en      <= 1'b0;
      gen_req     <= 1'b0;
      tx_den      <= 1'b0;
    end else begin
      line_tx_bit <= line_next;
      rx_out_bit  <= rxo_next;
      rx_out_pay  <= q_rx;
      chk_bit     <= chk_next;
      chk_en      <= chk_en_next;
      gen_req     <= gen_on_line || gen_on_rx;
      tx_den      <= q_tx;
    end
  end
endmodule

// File: rtl/lbm_router_chk.sv
module lbm_router_chk (
  input logic clk,
  input logic rst_n,
  input logic diag_lb,
  input logic line_lb,
  input logic pay_lb,
  input logic ais_en,
  input logic line_rx_bit,
  input logic rx_pay,
  input logic tx_pay,
  input logic line_tx_bit,
  input logic rx_out_pay,
  input logic chk_en,
  input logic gen_req,
  input logic tx_den
);
  assert_ais_forced_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (diag_lb && ais_en) |=> line_tx_bit);

  assert_line_loop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (line_lb && !diag_lb) |=> (line_tx_bit == $past(line_rx_bit)));

  assert_diag_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
    diag_lb |=> (rx_out_pay == $past(tx_pay)));

  assert_pay_realign_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pay_lb && !diag_lb && !line_lb) |=> (tx_den == $past(rx_pay)));

  assert_chk_qualified_R12: assert property (@(posedge clk) disable iff (!rst_n)
    chk_en |-> (rx_out_pay || tx_den));

  assert_gen_qualified_R11: assert property (@(posedge clk) disable iff (!rst_n)
    gen_req |-> (rx_out_pay || tx_den));
endmodule

bind lbm_router lbm_router_chk u_chk (.*);

// File: tb/lbm_router_test.sv
module lbm_router_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic diag_lb = 0, line_lb = 0, pay_lb = 0, ais_en = 0;
  logic [1:0] bert_mode = 2'b00;
  logic line_rx_bit = 0, rx_pay = 0, tx_bit = 0, tx_pay = 0, gen_bit = 0;
  logic oh_en = 0, oh_bit = 0;
  logic line_tx_bit, rx_out_bit, rx_out_pay, chk_bit, chk_en, gen_req, tx_den;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  typedef struct {
    logic line, rxo, rxq, chk, chke, gen, den;
    string tl, tr, tq;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  lbm_router uut (.*);

  task automatic check(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  // Independent reference written from the requirement text.
  function automatic exp_t model();
    exp_t e;
    bit d, l, p, dirx, qt, qr, gline, pre;
    d = diag_lb; l = line_lb && !d; p = pay_lb && !d && !l;
    dirx = bert_mode[1];
    qt = p ? rx_pay : tx_pay;
    qr = d ? tx_pay : rx_pay;
    gline = (!d && !l && !p && !dirx) || (p && bert_mode == 2'b01);
    if (l) pre = line_rx_bit;
    else if (oh_en) pre = oh_bit;
    else if (!qt) pre = tx_bit;
    else if (gline) pre = gen_bit;
    else if (p) pre = line_rx_bit;
    else pre = tx_bit;
    e.line = (d && ais_en) ? 1'b1 : pre;
    if (qr && dirx) e.rxo = gen_bit;
    else e.rxo = d ? pre : line_rx_bit;
    e.chk  = dirx ? tx_bit : (d ? pre : line_rx_bit);
    e.chke = dirx ? qt : qr;
    e.gen  = (gline && qt) || (dirx && qr);
    e.den  = qt;
    e.rxq  = qr;
    e.tl = (d && ais_en) ? "R6" : (l ? "R4" : (oh_en ? "R10" : (!qt ? "R9" :
           (d ? "R5" : (p ? "R7" : "R3")))));
    if ((diag_lb + line_lb + pay_lb) > 1) e.tl = {e.tl, "/R8"};
    e.tr = !qr ? "R9" : (d ? "R5" : (l ? "R4" : (p ? "R7" : "R3")));
    e.tq = d ? "R5" : (p ? "R7" : "R2");
    return e;
  endfunction

  // Monitor: one item per cycle, sampled just after the edge.
  initial begin
    forever begin
      @(posedge clk); #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check(e.tl, line_tx_bit, e.line, "line_tx_bit");
        check(e.tr, rx_out_bit, e.rxo, "rx_out_bit");
        check(e.tq, rx_out_pay, e.rxq, "rx_out_pay");
        check("R3/R12 chk", chk_bit, e.chk, "chk_bit");
        check("R12", chk_en, e.chke, "chk_en");
        check("R11", gen_req, e.gen, "gen_req");
        check(e.tq == "R5" ? "R2" : e.tq, tx_den, e.den, "tx_den");
      end
    end
  end

  // Watchdog
  initial begin
    #2000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state while inputs toggle
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      {line_rx_bit, tx_bit, gen_bit, rx_pay, tx_pay, oh_en, oh_bit, ais_en, diag_lb} = 9'h1FF;
      #2;
      check("R1", line_tx_bit, 1'b0, "line_tx_bit");
      check("R1", rx_out_bit, 1'b0, "rx_out_bit");
      check("R1", chk_en, 1'b0, "chk_en");
      check("R1", gen_req, 1'b0, "gen_req");
      check("R1", tx_den, 1'b0, "tx_den");
    end
    @(negedge clk);
    rst_n = 1'b1;
    for (int seg = 0; seg < 64; seg++) begin
      for (int c = 0; c < 40; c++) begin
        @(negedge clk);
        {ais_en, bert_mode, pay_lb, line_lb, diag_lb} = 6'(seg);
        line_rx_bit = 1'($urandom); tx_bit = 1'($urandom); gen_bit = 1'($urandom);
        rx_pay = ($urandom % 4) != 0; tx_pay = ($urandom % 4) != 0;
        oh_en = ($urandom % 5) == 0; oh_bit = 1'($urandom);
        sb.push_back(model());
      end
    end
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule